// File: doc/BRIEF.md
# Exhaustive Serial Pattern Tester

This block is a built-in self-test sequencer for a one-bit serial Mealy detector. The detector sees its input in non-overlapping groups of `CASE_BITS` bits. It raises its output on the last bit of a group when that group holds exactly one zero. For the default width of three, that means the groups with two ones and one zero.

After a start request, the tester counts through every possible group value in ascending order. For each value it takes these steps:
- It pulses the detector's reset for one clock.
- It drives the group bits onto the detector's data line, most significant bit first, one bit per clock.
- In the same cycle that each bit is driven, it compares the detector's combinational output with the value the group should give.

A pulse marks the end of each case and reports whether that case passed. The first failing case number is held, together with a sticky error flag. When the last case has finished, `done_o` rises and `ok_o` reports a clean run.

Top module: `pattern_sweep_tester`

## Requirements
- R1: While `rst_ni` is low and after it is released, `busy_o`, `done_o`, `ok_o`, `err_o`, `case_done_o`, `dut_rst_o` and `dut_data_o` are all 0, and `fail_case_o` is 0.
- R2: A high `start_i` sampled while `busy_o` is low begins a sweep over case values 0 to 7 in ascending order. Each case is reported exactly once by a one-cycle `case_done_o` pulse, with `case_idx_o` equal to that case value.
- R3: Each case opens with `dut_rst_o` high for exactly one clock, during which `dut_data_o` is 0. There are eight such pulses per sweep.
- R4: In the three clocks right after each reset pulse, `dut_data_o` carries the case bits most significant first. Case 6 gives 1, 1, 0.
- R5: The detector output is sampled in the same cycle each bit is driven. The expected value is 0 on the first two bits of every case. On the third bit it is 1 for cases 3, 5 and 6 and 0 for the other cases. `case_pass_o` (valid with `case_done_o`) is 1 only when all three samples match.
- R6: `err_o` sets on the first failing case and stays set until the next accepted start. `fail_case_o` holds the number of that first failing case.
- R7: `done_o` rises on the 40th rising edge after the edge that accepts the start. At that point `busy_o` is 0 and `ok_o` equals the inverse of `err_o`.
- R8: `start_i` has no effect while `busy_o` is high. The sweep still reports exactly eight cases in order.
- R9: A start accepted after `done_o` clears `done_o`, `err_o`, `fail_case_o` and the case counter, and runs a fresh sweep.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a sweep (honoured only when idle) |
| dut_rst_o | output | 1 | Active-high synchronous reset to the detector |
| dut_data_o | output | 1 | Serial data to the detector |
| dut_out_i | input | 1 | Detector Mealy output |
| busy_o | output | 1 | Sweep in progress |
| case_idx_o | output | CASE_BITS | Current case value |
| case_done_o | output | 1 | One-cycle end-of-case strobe |
| case_pass_o | output | 1 | Case result, valid with case_done_o |
| err_o | output | 1 | Sticky error flag |
| fail_case_o | output | CASE_BITS | First failing case |
| done_o | output | 1 | Sweep finished |
| ok_o | output | 1 | Sweep finished with no error |

## Verification
The assertions assume that `start_i` is a clean synchronous level. They also assume that `dut_out_i` settles within the cycle as a function of the detector state and `dut_data_o` only. The bench meets the first assumption by driving `start_i` on falling edges. It meets the second by modelling the detector as a register set with combinational output logic, updated on rising edges and reset synchronously by `dut_rst_o`. Faults are injected only by adding output terms to that model, so the detector output stays a legal Mealy function.

// File: rtl/pst_pkg.sv
package pst_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RESET = 2'd1,
    ST_SHIFT = 2'd2,
    ST_NEXT  = 2'd3
  } pst_state_e;

  // Output expected on bit position idx (0 = first sent) of a case.
  function automatic logic exp_bit(input int unsigned width,
                                   input logic [31:0] case_val,
                                   input int unsigned idx);
    int unsigned ones;
    ones = 0;
    for (int i = 0; i < 32; i++)
      if (i < int'(width)) ones += int'(case_val[i]);
    return (idx == width - 1) && (ones == width - 1);
  endfunction
endpackage

// File: rtl/pst_counter.sv
module pst_counter #(
  parameter int unsigned CASE_BITS = 3,
  localparam int unsigned IDX_W = (CASE_BITS > 1) ? $clog2(CASE_BITS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 case_inc_i,
  input  logic                 bit_clr_i,
  input  logic                 bit_inc_i,
  output logic [CASE_BITS-1:0] case_q_o,
  output logic [IDX_W-1:0]     bit_q_o,
  output logic                 last_case_o,
  output logic                 last_bit_o
);
  localparam logic [CASE_BITS-1:0] CASE_MAX = '1;
  localparam logic [IDX_W-1:0]     BIT_MAX  = IDX_W'(CASE_BITS - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          case_q_o <= '0;
    else if (clr_i)       case_q_o <= '0;
    else if (case_inc_i)  case_q_o <= case_q_o + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          bit_q_o <= '0;
    else if (bit_clr_i)   bit_q_o <= '0;
    else if (bit_inc_i)   bit_q_o <= bit_q_o + 1'b1;
  end

  assign last_case_o = (case_q_o == CASE_MAX);
  assign last_bit_o  = (bit_q_o == BIT_MAX);
endmodule

// File: rtl/pst_ctrl.sv
module pst_ctrl
  import pst_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       last_case_i,
  input  logic       last_bit_i,
  output pst_state_e state_o,
  output logic       clr_o,
  output logic       case_inc_o,
  output logic       bit_clr_o,
  output logic       bit_inc_o
);
  pst_state_e state_d;

  always_comb begin
    state_d    = state_o;
    clr_o      = 1'b0;
    case_inc_o = 1'b0;
    bit_clr_o  = 1'b0;
    bit_inc_o  = 1'b0;
    unique case (state_o)
      ST_IDLE: if (start_i) begin
        state_d = ST_RESET;
        clr_o   = 1'b1;
      end
      ST_RESET: begin
        state_d   = ST_SHIFT;
        bit_clr_o = 1'b1;
      end
      ST_SHIFT: begin
        if (last_bit_i) state_d = ST_NEXT;
        else            bit_inc_o = 1'b1;
      end
      ST_NEXT: begin
        if (last_case_i) state_d = ST_IDLE;
        else begin
          state_d    = ST_RESET;
          case_inc_o = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_o <= ST_IDLE;
    else         state_o <= state_d;
  end
endmodule

// File: rtl/pst_stim.sv
module pst_stim #(
  parameter int unsigned CASE_BITS = 3,
  localparam int unsigned IDX_W = (CASE_BITS > 1) ? $clog2(CASE_BITS) : 1
) (
  input  logic                 shifting_i,
  input  logic [CASE_BITS-1:0] case_i,
  input  logic [IDX_W-1:0]     bit_i,
  output logic                 data_o,
  output logic                 exp_o
);
  logic [CASE_BITS-1:0] exp_vec;

  // Expected output per bit position, position 0 sent first.
  for (genvar g = 0; g < CASE_BITS; g++) begin : g_exp
    assign exp_vec[g] = pst_pkg::exp_bit(CASE_BITS, 32'(case_i), g);
  end

  logic [IDX_W-1:0] msb_sel;
  assign msb_sel = IDX_W'(CASE_BITS - 1) - bit_i;
  assign data_o  = shifting_i & case_i[msb_sel];
  assign exp_o   = shifting_i & exp_vec[bit_i];
endmodule

// File: rtl/pst_score.sv
module pst_score #(
  parameter int unsigned CASE_BITS = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 case_start_i,
  input  logic                 shifting_i,
  input  logic                 dut_out_i,
  input  logic                 exp_i,
  input  logic                 case_end_i,
  input  logic                 last_case_i,
  input  logic [CASE_BITS-1:0] case_i,
  output logic                 case_pass_o,
  output logic                 err_o,
  output logic [CASE_BITS-1:0] fail_case_o,
  output logic                 done_o
);
  logic case_bad_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                case_bad_q <= 1'b0;
    else if (case_start_i)                      case_bad_q <= 1'b0;
    else if (shifting_i && (dut_out_i != exp_i)) case_bad_q <= 1'b1;
  end

  assign case_pass_o = case_end_i & ~case_bad_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_o       <= 1'b0;
      fail_case_o <= '0;
      done_o      <= 1'b0;
    end else if (clr_i) begin
      err_o       <= 1'b0;
      fail_case_o <= '0;
      done_o      <= 1'b0;
    end else if (case_end_i) begin
      if (case_bad_q && !err_o) begin
        err_o       <= 1'b1;
        fail_case_o <= case_i;
      end
      if (last_case_i) done_o <= 1'b1;
    end
  end
endmodule

// File: rtl/pattern_sweep_tester.sv
module pattern_sweep_tester
  import pst_pkg::*;
#(
  parameter int unsigned CASE_BITS = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  output logic                 dut_rst_o,
  output logic                 dut_data_o,
  input  logic                 dut_out_i,
  output logic                 busy_o,
  output logic [CASE_BITS-1:0] case_idx_o,
  output logic                 case_done_o,
  output logic                 case_pass_o,
  output logic                 err_o,
  output logic [CASE_BITS-1:0] fail_case_o,
  output logic                 done_o,
  output logic                 ok_o
);
  localparam int unsigned IDX_W = (CASE_BITS > 1) ? $clog2(CASE_BITS) : 1;

  pst_state_e       state;
  logic             clr, case_inc, bit_clr, bit_inc;
  logic             last_case, last_bit, shifting, exp_bit_w;
  logic [IDX_W-1:0] bit_q;

  pst_counter #(.CASE_BITS(CASE_BITS)) u_cnt (
    .clk_i, .rst_ni,
    .clr_i(clr), .case_inc_i(case_inc), .bit_clr_i(bit_clr), .bit_inc_i(bit_inc),
    .case_q_o(case_idx_o), .bit_q_o(bit_q),
    .last_case_o(last_case), .last_bit_o(last_bit)
  );

  pst_ctrl u_ctrl (
    .clk_i, .rst_ni, .start_i,
    .last_case_i(last_case), .last_bit_i(last_bit),
    .state_o(state), .clr_o(clr), .case_inc_o(case_inc),
    .bit_clr_o(bit_clr), .bit_inc_o(bit_inc)
  );

  assign shifting    = (state == ST_SHIFT);
  assign dut_rst_o   = (state == ST_RESET);
  assign case_done_o = (state == ST_NEXT);
  assign busy_o      = (state != ST_IDLE);

  pst_stim #(.CASE_BITS(CASE_BITS)) u_stim (
    .shifting_i(shifting), .case_i(case_idx_o), .bit_i(bit_q),
    .data_o(dut_data_o), .exp_o(exp_bit_w)
  );

  pst_score #(.CASE_BITS(CASE_BITS)) u_score (
    .clk_i, .rst_ni,
    .clr_i(clr), .case_start_i(dut_rst_o), .shifting_i(shifting),
    .dut_out_i, .exp_i(exp_bit_w), .case_end_i(case_done_o),
    .last_case_i(last_case), .case_i(case_idx_o),
    .case_pass_o, .err_o, .fail_case_o, .done_o
  );

  assign ok_o = done_o & ~err_o;
endmodule

// File: rtl/pst_checker.sv
module pst_checker #(
  parameter int unsigned CASE_BITS = 3
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 start_i,
  input logic                 dut_rst_o,
  input logic                 dut_data_o,
  input logic                 busy_o,
  input logic [CASE_BITS-1:0] case_idx_o,
  input logic                 case_done_o,
  input logic                 err_o,
  input logic [CASE_BITS-1:0] fail_case_o,
  input logic                 done_o,
  input logic                 ok_o
);
  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!dut_rst_o && !dut_data_o && !case_done_o));

  assert_case_strobe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    case_done_o |=> !case_done_o);

  assert_rst_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dut_rst_o |=> !dut_rst_o);

  assert_rst_data_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dut_rst_o |-> !dut_data_o);

  assert_next_case_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (case_done_o && !done_o) |=> (dut_rst_o || done_o));

  assert_err_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !(start_i && !busy_o)) |=> (err_o && $stable(fail_case_o)));

  assert_done_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && (ok_o == !err_o) && (&case_idx_o)));

  assert_busy_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !case_done_o) |=> busy_o);
endmodule

bind pattern_sweep_tester pst_checker #(.CASE_BITS(CASE_BITS)) u_pst_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
  .dut_rst_o(dut_rst_o), .dut_data_o(dut_data_o), .busy_o(busy_o),
  .case_idx_o(case_idx_o), .case_done_o(case_done_o), .err_o(err_o),
  .fail_case_o(fail_case_o), .done_o(done_o), .ok_o(ok_o)
);

// File: tb/pattern_sweep_tester_test.sv
`timescale 1ns/1ps
module pattern_sweep_tester_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic dut_rst, dut_data, dut_out, busy, case_done, case_pass, err, done, ok;
  logic [2:0] case_idx, fail_case;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  pattern_sweep_tester uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .dut_rst_o(dut_rst), .dut_data_o(dut_data), .dut_out_i(dut_out),
    .busy_o(busy), .case_idx_o(case_idx), .case_done_o(case_done),
    .case_pass_o(case_pass), .err_o(err), .fail_case_o(fail_case),
    .done_o(done), .ok_o(ok)
  );

  // Detector model: groups of three, flags exactly two ones.
  int        fault = 0;
  logic [1:0] d_cnt, d_ones;
  always_ff @(posedge clk) begin
    if (dut_rst || d_cnt == 2'd2) begin
      d_cnt  <= '0;
      d_ones <= '0;
    end else begin
      d_cnt  <= d_cnt + 1'b1;
      d_ones <= d_ones + 2'(dut_data);
    end
  end
  always_comb begin
    dut_out = (d_cnt == 2'd2) && ((d_ones + 2'(dut_data)) == 2'd2);
    if (fault == 1 && d_cnt == 2'd2 && d_ones == 2'd2 && dut_data) dut_out = 1'b1;
    if (fault == 2 && d_cnt == 2'd1 && d_ones == 2'd0 && dut_data) dut_out = 1'b1;
  end

  // Monitor of port activity.
  int   n_done, n_rst, since_rst, bad_pulse;
  logic pass_log [8];
  int   idx_log  [8];
  logic [2:0] cap [8];
  logic [2:0] cur;
  always @(posedge clk) begin
    if (dut_rst) begin
      n_rst++;
      if (dut_data) bad_pulse++;
      since_rst = 0;
      cur = '0;
    end else if (since_rst < 3) begin
      cur = {cur[1:0], dut_data};
      since_rst++;
      if (since_rst == 3) cap[case_idx] = cur;
    end
    if (case_done) begin
      if (n_done < 8) begin
        pass_log[n_done] = case_pass;
        idx_log[n_done]  = int'(case_idx);
      end
      n_done++;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  int run_edges;
  task automatic run_sweep(input int f, input bit poke_start);
    fault = f;
    n_done = 0; n_rst = 0; since_rst = 3; bad_pulse = 0;
    @(negedge clk) start = 1'b1;
    @(posedge clk);
    @(negedge clk) start = 1'b0;
    run_edges = 1;
    while (!done && run_edges < 500) begin
      if (poke_start && run_edges == 12) start = 1'b1;
      if (poke_start && run_edges == 14) start = 1'b0;
      @(posedge clk);
      @(negedge clk);
      run_edges++;
    end
    start = 1'b0;
  endtask

  function automatic bit good_exp(input int c);
    return (c == 3) || (c == 5) || (c == 6);
  endfunction

  task automatic test_reset();
    check("R1", "busy", int'(busy), 0);
    check("R1", "done", int'(done), 0);
    check("R1", "ok", int'(ok), 0);
    check("R1", "err", int'(err), 0);
    check("R1", "dut_rst", int'(dut_rst), 0);
    check("R1", "dut_data", int'(dut_data), 0);
    check("R1", "fail_case", int'(fail_case), 0);
  endtask

  task automatic test_clean_sweep();
    run_sweep(0, 0);
    check("R7", "edges to done", run_edges - 1, 40);
    check("R7", "ok", int'(ok), 1);
    check("R7", "busy", int'(busy), 0);
    check("R2", "case count", n_done, 8);
    check("R3", "reset pulses", n_rst, 8);
    check("R3", "data during reset", bad_pulse, 0);
    for (int c = 0; c < 8; c++) begin
      check("R2", $sformatf("order %0d", c), idx_log[c], c);
      check("R4", $sformatf("serial bits case %0d", c), int'(cap[c]), c);
      check("R5", $sformatf("pass case %0d", c), int'(pass_log[c]), 1);
    end
    check("R4", "case 6 order 110", int'(cap[6]), 6);
  endtask

  task automatic test_fault_mid();
    run_sweep(2, 0);
    check("R6", "err", int'(err), 1);
    check("R6", "first fail", int'(fail_case), 2);
    check("R7", "ok low", int'(ok), 0);
    for (int c = 0; c < 8; c++)
      check("R5", $sformatf("fault2 pass case %0d", c), int'(pass_log[c]),
            (c == 2 || c == 3) ? 0 : 1);
  endtask

  task automatic test_restart_clears();
    run_sweep(1, 0);
    check("R6", "last-case fault", int'(fail_case), 7);
    check("R5", "all-ones flagged", int'(pass_log[7]), 0);
    check("R5", "expected rule case 6", int'(good_exp(6)), 1);
    run_sweep(0, 0);
    check("R9", "err cleared", int'(err), 0);
    check("R9", "fail_case cleared", int'(fail_case), 0);
    check("R9", "ok", int'(ok), 1);
    check("R9", "fresh count", n_done, 8);
  endtask

  task automatic test_start_ignored();
    run_sweep(0, 1);
    check("R8", "case count", n_done, 8);
    check("R8", "edges to done", run_edges - 1, 40);
    for (int c = 0; c < 8; c++)
      check("R8", $sformatf("order %0d", c), idx_log[c], c);
    check("R8", "ok", int'(ok), 1);
  endtask

  initial begin
    n_done = 0; n_rst = 0; since_rst = 3; bad_pulse = 0;
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    test_reset();
    test_clean_sweep();
    test_fault_mid();
    test_restart_clears();
    test_start_ignored();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #50000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule